// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a parallel flash memory model. It tells a host whether an internal program or erase operation is still running. While the busy flag is high, every read returns a status word instead of the array contents. That word carries a polling bit and a toggle bit. When the busy flag drops, the read word shows the true array data again in the same cycle. A host can start polling at any time during an operation.

The host drives active-low chip-enable and output-enable pins. A read access begins in the cycle where both pins are first low together. Each new access made while the block is busy inverts the toggle bit once. Between accesses the toggle bit keeps its value. The timers that run the operation and the decoding of commands sit outside this block. Those parts supply the busy flag, the kind of operation, and the last data word loaded.

Top module: `opstat_reporter`

## Requirements
- R1: While `ce_n` or `oe_n` is high, `rd_oe` is 0 and `rd_word` is all zeros. This models the high-impedance bus.
- R2: While both enables are low and `busy` is 0, `rd_oe` is 1 and `rd_word` equals `array_word`.
- R3: While both enables are low, `busy` is 1 and `op_erase` is 0 (program), bit 7 of `rd_word` is the inverse of bit 7 of `load_word`.
- R4: While both enables are low, `busy` is 1 and `op_erase` is 1 (erase), bit 7 of `rd_word` is 0.
- R5: While both enables are low and `busy` is 1, every bit of `rd_word` except bits 7 and 6 is 0.
- R6: Bit 6 of `rd_word` inverts at each new read access that starts while `busy` is 1. A new access is the first cycle with both enables low after a cycle in which they were not both low. The new value is visible in that first cycle. The first such access after reset shows bit 6 equal to 1.
- R7: Bit 6 does not change in any of these cases:
  - within a single access;
  - across accesses made while `busy` is 0;
  - when `busy` rises in the middle of an access.
- R8: When `busy` falls during an access, `rd_word` equals `array_word` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Internal program or erase is running |
| op_erase | input | 1 | Kind of running operation: 0 is program, 1 is erase |
| load_word | input | 16 | Last data word loaded for programming |
| array_word | input | 16 | Word read from the array at the current address |
| rd_word | output | 16 | Word presented to the read bus |
| rd_oe | output | 1 | Output drive enable of the read bus |

## Verification
Random reads mix the two operation kinds with busy and idle phases. They use random values for `load_word` and `array_word`, and they vary which enable falls last. This separates the polling bit of a program operation from that of an erase, and it separates status words from array pass-through. Directed sequences cover the cases the random reads may miss:
- several reads made while idle, between busy reads, which tells a toggle that holds apart from one that advances on any access;
- `busy` rising in the middle of an access, which shows whether the toggle advances only when an access starts;
- `busy` falling in the middle of an access, which shows whether true data returns at once.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  localparam int unsigned WORD_W_DEF   = 16;
  localparam int unsigned POLL_POS_DEF = 7;
  localparam int unsigned TOG_POS_DEF  = 6;

  typedef enum logic {
    OPK_PROGRAM = 1'b0,
    OPK_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/opstat_access.sv
// Detects the start of a read access: both enables low for the first cycle.
module opstat_access (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic rd_en,
  output logic acc_start
);
  logic en_q;

  assign rd_en     = ~ce_n & ~oe_n;
  assign acc_start = rd_en & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= rd_en;
  end
endmodule

// File: rtl/opstat_toggle.sv
// Toggle state; the advanced value is visible in the cycle of the advance.
module opstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tog_now
);
  logic tog_q;

  assign tog_now = tog_q ^ adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_now;
  end
endmodule

// File: rtl/opstat_mux.sv
// Builds the status word and selects between status, array data and idle bus.
module opstat_mux
  import opstat_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned POLL_POS = POLL_POS_DEF,
  parameter int unsigned TOG_POS  = TOG_POS_DEF
) (
  input  logic              rd_en,
  input  logic              busy,
  input  op_kind_e          op_kind,
  input  logic [WORD_W-1:0] load_word,
  input  logic [WORD_W-1:0] array_word,
  input  logic              tog,
  output logic [WORD_W-1:0] rd_word
);
  logic              poll_bit;
  logic [WORD_W-1:0] status_word;

  assign poll_bit = (op_kind == OPK_ERASE) ? 1'b0 : ~load_word[POLL_POS];

  for (genvar b = 0; b < WORD_W; b++) begin : g_stat
    if (b == POLL_POS) begin : g_poll
      assign status_word[b] = poll_bit;
    end else if (b == TOG_POS) begin : g_tog
      assign status_word[b] = tog;
    end else begin : g_zero
      assign status_word[b] = 1'b0;
    end
  end

  always_comb begin
    if (!rd_en)    rd_word = '0;
    else if (busy) rd_word = status_word;
    else           rd_word = array_word;
  end
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
  import opstat_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned POLL_POS = POLL_POS_DEF,
  parameter int unsigned TOG_POS  = TOG_POS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic              op_erase,
  input  logic [WORD_W-1:0] load_word,
  input  logic [WORD_W-1:0] array_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_oe
);
  logic     rd_en;
  logic     acc_start;
  logic     tog_now;
  op_kind_e op_kind;

  assign op_kind = op_kind_e'(op_erase);
  assign rd_oe   = rd_en;

  opstat_access u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .rd_en     (rd_en),
    .acc_start (acc_start)
  );

  opstat_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (acc_start & busy),
    .tog_now (tog_now)
  );

  opstat_mux #(
    .WORD_W   (WORD_W),
    .POLL_POS (POLL_POS),
    .TOG_POS  (TOG_POS)
  ) u_mux (
    .rd_en      (rd_en),
    .busy       (busy),
    .op_kind    (op_kind),
    .load_word  (load_word),
    .array_word (array_word),
    .tog        (tog_now),
    .rd_word    (rd_word)
  );
endmodule

// File: rtl/opstat_reporter_chk.sv
module opstat_reporter_chk #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned POLL_POS = 7,
  parameter int unsigned TOG_POS  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              busy,
  input logic              op_erase,
  input logic [WORD_W-1:0] load_word,
  input logic [WORD_W-1:0] array_word,
  input logic [WORD_W-1:0] rd_word,
  input logic              rd_oe
);
  localparam logic [WORD_W-1:0] OTHER_MASK =
    ~((WORD_W'(1) << POLL_POS) | (WORD_W'(1) << TOG_POS));

  logic en_q, busy_q, b6_q, have_b6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      b6_q    <= 1'b0;
      have_b6 <= 1'b0;
    end else begin
      en_q   <= rd_oe;
      busy_q <= busy;
      if (rd_oe && busy) begin
        b6_q    <= rd_word[TOG_POS];
        have_b6 <= 1'b1;
      end
    end
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!rd_oe && rd_word == '0));
  // R2
  pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !busy) |-> (rd_oe && rd_word == array_word));
  // R3
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && busy && !op_erase) |-> (rd_word[POLL_POS] == !load_word[POLL_POS]));
  // R4
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && busy && op_erase) |-> (rd_word[POLL_POS] == 1'b0));
  // R5
  status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && busy) |-> ((rd_word & OTHER_MASK) == '0));
  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && !en_q && busy && have_b6) |-> (rd_word[TOG_POS] != b6_q));
  // R7
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && en_q && busy && have_b6) |-> (rd_word[TOG_POS] == b6_q));
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && busy_q && !busy) |-> (rd_word == array_word));
endmodule

bind opstat_reporter opstat_reporter_chk #(
  .WORD_W   (WORD_W),
  .POLL_POS (POLL_POS),
  .TOG_POS  (TOG_POS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .busy       (busy),
  .op_erase   (op_erase),
  .load_word  (load_word),
  .array_word (array_word),
  .rd_word    (rd_word),
  .rd_oe      (rd_oe)
);

// File: tb/opstat_reporter_tb.sv
module opstat_reporter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0, op_erase = 1'b0;
  logic [15:0] load_word = '0, array_word = '0;
  logic [15:0] rd_word;
  logic        rd_oe;

  int checks = 0, errors = 0;
  bit tog_m = 1'b0;

  always #5 clk = ~clk;

  opstat_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .op_erase(op_erase), .load_word(load_word), .array_word(array_word),
    .rd_word(rd_word), .rd_oe(rd_oe)
  );

  function automatic logic [15:0] exp_word(bit b, bit e, logic [15:0] ld,
                                           logic [15:0] ar, bit tg);
    logic [15:0] w;
    if (!b) return ar;
    w = '0;
    w[7] = e ? 1'b0 : ~ld[7];
    w[6] = tg;
    return w;
  endfunction

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // One full read access. ce_first chooses which enable falls last.
  task automatic access(bit b, bit e, logic [15:0] ld, logic [15:0] ar, bit ce_first);
    step();
    busy = b; op_erase = e; load_word = ld; array_word = ar;
    step();
    if (ce_first) ce_n = 1'b0; else oe_n = 1'b0;
    @(negedge clk);
    chk("R1 one enable", {rd_oe, rd_word}, 17'h0);
    step();
    ce_n = 1'b0; oe_n = 1'b0;
    if (b) tog_m = ~tog_m;
    @(negedge clk);
    chk(b ? (e ? "R4/R5/R6 erase status" : "R3/R5/R6 program status") : "R2 pass",
        {rd_oe, rd_word}, {1'b1, exp_word(b, e, ld, ar, tog_m)});
    step();
    @(negedge clk);
    chk("R7 hold in access", {rd_oe, rd_word}, {1'b1, exp_word(b, e, ld, ar, tog_m)});
    step();
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {rd_oe, rd_word}, 17'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {rd_oe, rd_word}, 17'h0);

    // R6: first busy read after reset shows 1
    access(1'b1, 1'b0, 16'h0080, 16'h1234, 1'b0);
    access(1'b1, 1'b0, 16'h0000, 16'h1234, 1'b1);
    // R7: idle reads hold the toggle
    access(1'b0, 1'b0, 16'h0, 16'hBEEF, 1'b0);
    access(1'b0, 1'b1, 16'h0, 16'h00C0, 1'b1);
    access(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);

    // R7: busy rising mid-access does not advance
    step(); busy = 1'b0; array_word = 16'h5A5A;
    step(); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk("R2 before busy", {rd_oe, rd_word}, {1'b1, 16'h5A5A});
    step(); busy = 1'b1; op_erase = 1'b0; load_word = 16'h0000;
    @(negedge clk);
    chk("R7 busy rise mid", {rd_oe, rd_word}, {1'b1, exp_word(1'b1, 1'b0, 16'h0, 16'h0, tog_m)});
    // R8: busy falls mid-access
    step(); busy = 1'b0;
    @(negedge clk); chk("R8 busy fall", {rd_oe, rd_word}, {1'b1, 16'h5A5A});
    step(); ce_n = 1'b1; oe_n = 1'b1;

    for (int i = 0; i < 300; i++) begin
      access(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule